// File: doc/BRIEF.md
# Histogram accumulator engine

This block counts how often each sample code occurs. A start pulse sets it running. It first writes zero to every bin of an on-chip counter table. It then turns each accepted sample into a bin address. For that sample it reads the bin, adds one and writes the new value back. This update spans three clock cycles, and samples that arrive while an update is still in flight are discarded. Because the kept samples are spread evenly in time, the histogram keeps its statistical meaning even though most samples are thrown away.

Counting ends as soon as any bin reaches a target chosen by a 2-bit select. The whole table is then returned in ascending address order on a valid/ready stream. The block stays busy from the start pulse until the last bin is handed over. Deployed with `ADDR_W` = 15 it keeps 32768 bins.

Top module: `hist_engine`

## Requirements
- R1: After reset `busy` and `out_valid` are low.
- R2: A `start` pulse while idle captures `tgt_sel` and `width_sel`, raises `busy` on the next cycle and writes zero to all 2^ADDR_W bins, one per cycle. No count survives from an earlier run.
- R3: The source width is W = NARROW_W + 2*`width_sel`. The bin index is formed from the low W bits of `smp_data` with bit W-1 inverted, so two's complement becomes offset binary. Bits above W are ignored. When W > ADDR_W the top ADDR_W bits of that value form the index; otherwise it is zero-extended.
- R4: In the counting phase a sample with `smp_valid` high is taken unless an update is pending. A sample taken at clock edge a blocks edges a+1 and a+2, and a valid sample at edge a+3 is taken again.
- R5: Each taken sample raises its bin by exactly one, saturating at all ones.
- R6: `tgt_sel` values 0, 1, 2 and 3 give targets of 2^TGT_LOG2, 2^(TGT_LOG2-1), 2^(TGT_LOG2-2) and 2^(TGT_LOG2-3). Counting stops when a bin reaches the target, and every later sample is ignored.
- R7: After counting stops, all bins leave on `out_count` in ascending address order, one per `out_valid` && `out_ready` transfer. `out_count` is held while `out_valid` waits for `out_ready`.
- R8: `busy` stays high until the last bin is transferred and is low in the cycle after that transfer.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new histogram run (ignored while busy) |
| tgt_sel | input | 2 | Stop-count select |
| width_sel | input | 2 | Source width select |
| smp_data | input | NARROW_W+6 | Sample code, LSB aligned |
| smp_valid | input | 1 | Sample strobe |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Bin count available |
| out_ready | input | 1 | Consumer accepts the bin count |
| out_count | output | CNT_W | Bin count, ascending bin order |

## Verification
The bench builds the engine with ADDR_W = 6, NARROW_W = 4, TGT_LOG2 = 5 and CNT_W = 8. With 64 bins, each clear and each readout takes only a few hundred cycles, so back-to-back runs stay short and check that nothing survives the clear. The four source widths of 4, 6, 8 and 10 bits exercise both the zero-extended index and the truncated index. Targets of 32 down to 4 are reached within a few thousand cycles under sparse, continuous, constant and extreme-code streams, so the drop pattern and the early stop are visible in every bin that is read back.

// File: rtl/hist_pkg.sv
package hist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_WAIT,
      ST_READ,
      ST_WRITE,
      ST_FETCH,
      ST_SHOW
   } hist_state_e;
endpackage

// File: rtl/hist_spram.sv
module hist_spram #(
   parameter int AW = 12,
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // single port, registered read; rdata holds between reads
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/hist_bin_map.sv
module hist_bin_map #(
   parameter int ADDR_W   = 12,
   parameter int NARROW_W = 12
) (
   input  logic [NARROW_W+5:0] sample,
   input  logic [1:0]          width_sel,
   output logic [ADDR_W-1:0]   bin
);
   logic [ADDR_W-1:0] cand [4];

   // one candidate index per selectable source width
   for (genvar g = 0; g < 4; g++) begin : g_width
      localparam int W = NARROW_W + 2*g;
      if (W > ADDR_W) begin : g_trunc
         assign cand[g] = {~sample[W-1], sample[W-2 -: ADDR_W-1]};
      end else if (W == ADDR_W) begin : g_exact
         assign cand[g] = {~sample[W-1], sample[W-2:0]};
      end else begin : g_ext
         assign cand[g] = {{(ADDR_W-W){1'b0}}, ~sample[W-1], sample[W-2:0]};
      end
   end

   assign bin = cand[width_sel];
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl import hist_pkg::*; #(
   parameter int ADDR_W   = 12,
   parameter int CNT_W    = 24,
   parameter int TGT_LOG2 = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        tgt_sel,
   input  logic [1:0]        width_sel,
   input  logic              smp_valid,
   input  logic [ADDR_W-1:0] map_bin,
   output logic [1:0]        cfg_width,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [CNT_W-1:0]  ram_wdata,
   input  logic [CNT_W-1:0]  ram_rdata,
   input  logic              out_ready,
   output logic              out_valid,
   output logic              busy
);
   hist_state_e       state;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] bin_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              hit_q;
   logic [1:0]        tsel_q;
   logic [1:0]        wsel_q;
   logic [CNT_W-1:0]  target;
   logic [CNT_W-1:0]  inc;
   logic              ptr_last;
   logic              take;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign target    = ONE << (TGT_LOG2 - int'(tsel_q));
   assign inc       = (&ram_rdata) ? ram_rdata : ram_rdata + ONE;
   assign ptr_last  = &ptr;
   assign take      = (state == ST_WAIT) && smp_valid;
   assign cfg_width = wsel_q;
   assign busy      = (state != ST_IDLE);
   assign out_valid = (state == ST_SHOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ptr    <= '0;
         bin_q  <= '0;
         cnt_q  <= '0;
         hit_q  <= 1'b0;
         tsel_q <= '0;
         wsel_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               tsel_q <= tgt_sel;
               wsel_q <= width_sel;
               ptr    <= '0;
               state  <= ST_CLEAR;
            end
            ST_CLEAR: begin
               ptr <= ptr + 1'b1;
               if (ptr_last) state <= ST_WAIT;
            end
            ST_WAIT: if (smp_valid) begin
               bin_q <= map_bin;
               state <= ST_READ;
            end
            ST_READ: begin
               cnt_q <= inc;
               hit_q <= (inc >= target);
               state <= ST_WRITE;
            end
            ST_WRITE: begin
               ptr   <= '0;
               state <= hit_q ? ST_FETCH : ST_WAIT;
            end
            ST_FETCH: state <= ST_SHOW;
            ST_SHOW: if (out_ready) begin
               ptr   <= ptr + 1'b1;
               state <= ptr_last ? ST_IDLE : ST_FETCH;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = ptr;
      ram_wdata = cnt_q;
      unique case (state)
         ST_CLEAR: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_wdata = '0;
         end
         ST_WAIT: begin
            ram_en   = smp_valid;
            ram_addr = map_bin;
         end
         ST_WRITE: begin
            ram_en   = 1'b1;
            ram_we   = 1'b1;
            ram_addr = bin_q;
         end
         ST_FETCH: ram_en = 1'b1;
         default: ;
      endcase
   end

   // R4: two dead cycles after every taken sample
   p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take ##1 !take);

   // R5 / R6: a written count is never zero and never passes the target
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && state == ST_WRITE) |-> (ram_wdata != '0 && ram_wdata <= target));

   // R7: held output while the consumer stalls
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(ram_rdata)));

   // R8: busy only falls right after a transfer
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(out_valid && out_ready));

   // R9: start while running never restarts the clear
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE && state != ST_CLEAR) |=> (state != ST_CLEAR));
endmodule

// File: rtl/hist_engine.sv
module hist_engine #(
   parameter int ADDR_W   = 12,
   parameter int CNT_W    = 24,
   parameter int TGT_LOG2 = 14,
   parameter int NARROW_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          tgt_sel,
   input  logic [1:0]          width_sel,
   input  logic [NARROW_W+5:0] smp_data,
   input  logic                smp_valid,
   output logic                busy,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [CNT_W-1:0]    out_count
);
   if (ADDR_W < 2 || NARROW_W < 2) begin : g_bad_width
      $error("hist_engine: ADDR_W and NARROW_W must be at least 2");
   end
   if (TGT_LOG2 < 3 || CNT_W <= TGT_LOG2) begin : g_bad_target
      $error("hist_engine: need 3 <= TGT_LOG2 < CNT_W");
   end

   logic [1:0]        cfg_width;
   logic [ADDR_W-1:0] map_bin;
   logic              ram_en;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [CNT_W-1:0]  ram_wdata;
   logic [CNT_W-1:0]  ram_rdata;

   hist_bin_map #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_map (
      .sample    (smp_data),
      .width_sel (cfg_width),
      .bin       (map_bin)
   );

   hist_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TGT_LOG2(TGT_LOG2)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tgt_sel   (tgt_sel),
      .width_sel (width_sel),
      .smp_valid (smp_valid),
      .map_bin   (map_bin),
      .cfg_width (cfg_width),
      .ram_en    (ram_en),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_rdata (ram_rdata),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .busy      (busy)
   );

   hist_spram #(.AW(ADDR_W), .DW(CNT_W)) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   assign out_count = ram_rdata;
endmodule

// File: tb/sim_hist_engine.sv
module sim_hist_engine;
   localparam int AW = 6;
   localparam int NW = 4;
   localparam int TL = 5;
   localparam int CW = 8;
   localparam int SW = NW + 6;
   localparam int NB = 1 << AW;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    tgt_sel = '0;
   logic [1:0]    width_sel = '0;
   logic [SW-1:0] smp_data = '0;
   logic          smp_valid = 1'b0;
   logic          busy;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [CW-1:0] out_count;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int model [NB];

   hist_engine #(.ADDR_W(AW), .CNT_W(CW), .TGT_LOG2(TL), .NARROW_W(NW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .tgt_sel(tgt_sel),
      .width_sel(width_sel), .smp_data(smp_data), .smp_valid(smp_valid),
      .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
      .out_count(out_count)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL R8 watchdog expired: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R3 reference index
   function automatic int ref_bin(input int d, input int ws);
      int w;
      int f;
      w = NW + 2*ws;
      f = d & ((1 << w) - 1);
      f = f ^ (1 << (w - 1));
      if (w > AW) f = f >> (w - AW);
      return f;
   endfunction

   // mode 0 sparse random, 1 continuous random, 2 constant code, 3 extreme codes
   task automatic run(input int tsel, input int wsel, input int mode);
      int target;
      int cool;
      int w;
      int k;
      int extra;
      int idx;
      int code;
      bit hit;
      bit v;
      bit r;
      int d;
      target = 1 << (TL - tsel);
      w = NW + 2*wsel;
      code = $urandom % (1 << SW);
      @(negedge clk);
      start = 1'b1;
      tgt_sel = 2'(tsel);
      width_sel = 2'(wsel);
      @(negedge clk);
      start = 1'b0;
      tgt_sel = 2'(~tsel);
      width_sel = 2'(~wsel);
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      for (int i = 0; i < NB + 2; i++) @(negedge clk);
      for (int i = 0; i < NB; i++) model[i] = 0;
      cool = 0;
      hit = 1'b0;
      k = 0;
      extra = 8;
      while (!hit || extra > 0) begin
         case (mode)
            0: begin v = 1'($urandom % 2); d = $urandom % (1 << SW); end
            1: begin v = 1'b1; d = $urandom % (1 << SW); end
            2: begin v = 1'b1; d = code; end
            default: begin
               v = (k % 3 == 0);
               d = ($urandom % (1 << SW)) & ~((1 << w) - 1);
               case ((k / 3) % 3)
                  0: d = d | (1 << (w - 1));
                  1: d = d | ((1 << (w - 1)) - 1);
                  default: ;
               endcase
            end
         endcase
         smp_valid = v;
         smp_data = SW'(d);
         start = (k == 5);
         // R4 / R5 / R6 reference acceptance
         if (!hit) begin
            if (cool > 0) cool = cool - 1;
            else if (v) begin
               int b;
               b = ref_bin(d, wsel);
               if (model[b] < CMAX) model[b] = model[b] + 1;
               cool = 2;
               if (model[b] >= target) hit = 1'b1;
            end
         end else begin
            extra = extra - 1;
         end
         k = k + 1;
         @(negedge clk);
      end
      smp_valid = 1'b0;
      start = 1'b0;
      idx = 0;
      while (idx < NB) begin
         r = ($urandom % 4) != 0;
         out_ready = r;
         start = (idx == NB / 2);
         if (out_valid && r) begin
            chk(out_count == CW'(model[idx]), $sformatf("R3 R4 R5 R6 R7 R2 bin %0d", idx),
                int'(out_count), model[idx]);
            if (idx == NB - 1) chk(busy == 1'b1, "R8 busy before last", int'(busy), 1);
            idx = idx + 1;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      start = 1'b0;
      chk(busy == 1'b0, "R8 busy after last", int'(busy), 0);
      chk(out_valid == 1'b0, "R7 no data after last", int'(out_valid), 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      #1;
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      run(0, 0, 0);
      run(1, 1, 1);
      run(2, 2, 3);
      run(3, 3, 2);
      run(0, 3, 0);
      run(3, 2, 1);
      run(1, 1, 3);
      run(2, 0, 3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule